// File: doc/BRIEF.md
# Carrier Burst and Line-Code Output Modulator

This block drives one output line from a timer-style clock source. It has three modes. In carrier mode it generates a rectangular carrier and passes a set number of whole carrier periods before it stops. A 4-bit clock divider and a 2-bit duty field set the carrier's period and its high time. In the two line-code modes it takes a serial bit stream, one bit at a time, through a request handshake. It encodes each bit as either Manchester or Biphase (differential) symbols, over a programmable half-bit time. A bit counter ends the frame after any number of bits, so frame lengths are not limited to whole bytes.

A user sets the configuration inputs and pulses `start` while the block is idle. The block latches the configuration on that edge and runs the burst or frame. It then raises `done` and holds the line low until the next accepted start. In the line-code modes, the first data bit must be present on `ser_data` together with `start`. Each later bit is requested with a one-cycle `data_req` pulse.

Top module: `carrier_biphase_mod`

## Requirements
- R1: In the cycle after a clock edge with `rst` high, `mod_out`, `data_req` and `done` are all 0.
- R2: Mode encoding: 0 selects carrier, 1 Manchester, 2 Biphase and 3 is reserved. A start is accepted on an edge where the block is idle, `start` is 1 and `mode` is not 3. Active cycles are numbered k = 0, 1, … from the cycle after the accepting edge. In carrier mode with divider value d and duty value u, cycle k has carrier level 1 when floor((floor(k/(d+1)) mod 64)/16) < u, which gives a period of 64·(d+1) clocks. `mod_out` shows the level of cycle k during cycle k+1.
- R3: Duty value 0 keeps `mod_out` low for the whole burst. Duty value 3 gives a level that is high in 48 of every 64 divided steps.
- R4: A carrier burst lasts `pulse_cnt`·64·(d+1) active cycles. `done` rises on the edge that closes the last active cycle and stays high until the next accepted start. From the following cycle `mod_out` is 0.
- R5: In Manchester mode each bit lasts 2·(h+1) cycles, where h is `half_len`. A 1 is high in the first half and low in the second. A 0 is low in the first half and high in the second.
- R6: In Biphase mode the level inverts at every bit start, with the level before the first bit taken as 0. A 0 bit inverts the level again at mid-bit, and a 1 bit keeps it for the whole bit.
- R7: A line-code frame holds exactly `bit_len` bits, for any value from 1 to 255, including lengths that are not multiples of 8. `done` rises on the edge that closes the last bit's final cycle, and `mod_out` is 0 afterwards.
- R8: Bit 0 is taken from `ser_data` on the accepting edge. `data_req` is 1 for exactly the last cycle of each bit that has a successor, and is never 1 together with `done`. The next bit is taken from `ser_data` on the edge that ends that cycle.
- R9: If an accepted start has a count of 0 (`pulse_cnt` in carrier mode, `bit_len` in the line-code modes), `done` is 1 right after the accepting edge, there are no active cycles and `mod_out` stays 0.
- R10: While a burst or frame runs, `start` and every configuration input are ignored. A start with mode 3 is ignored and leaves `done` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse for a burst or frame |
| mode | input | 2 | 0 carrier, 1 Manchester, 2 Biphase, 3 reserved |
| div_sel | input | 4 | Carrier divider value d (step = d+1 clocks) |
| duty | input | 2 | Carrier duty value u (u quarters high) |
| pulse_cnt | input | 8 | Carrier periods per burst |
| half_len | input | 8 | Half-bit time h (h+1 clocks) |
| bit_len | input | 8 | Bits per frame |
| ser_data | input | 1 | Serial data bit |
| data_req | output | 1 | Next-bit request, one cycle before a bit boundary |
| mod_out | output | 1 | Modulated output line |
| done | output | 1 | Burst or frame finished |

## Verification
The bench runs frames with a one-clock half bit, where the request for the next bit falls in the second cycle of the bit. A design that tied the request to the mid-bit point would fire it at the wrong time or skip it. Biphase frames with mixed bit values check that the level carries over between bits: a coder that reset its memory at each bit would flip symbols after the first 1. Odd frame lengths such as 11 and 13 bits show whether the bit counter is off by one or rounds to bytes. Zero counts, a second start in mid-burst, configuration changes during a burst and a reserved-mode start catch designs that relaunch, re-read their inputs or disturb `done`.

// File: rtl/cbm_pkg.sv
package cbm_pkg;
  typedef enum logic [1:0] {
    MOD_CARRIER = 2'd0,
    MOD_MANCH   = 2'd1,
    MOD_BIPH    = 2'd2,
    MOD_RSVD    = 2'd3
  } mod_mode_e;
endpackage

// File: rtl/cbm_carrier_gen.sv
// Carrier prescaler: a divider tick feeds a phase counter whose low bits
// form the fine step and whose top bits are compared against the duty value.
module cbm_carrier_gen #(
  parameter int DIV_W  = 4,
  parameter int STEP_W = 4,
  parameter int DUTY_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              en,
  input  logic [DIV_W-1:0]  div,
  input  logic [DUTY_W-1:0] duty,
  output logic              level,
  output logic              period_end
);
  localparam int PH_W = STEP_W + DUTY_W;

  logic [DIV_W-1:0] tick;
  logic [PH_W-1:0]  phase;
  logic             tick_wrap;

  assign tick_wrap  = (tick == div);
  assign period_end = tick_wrap && (phase == {PH_W{1'b1}});
  assign level      = (phase[PH_W-1 -: DUTY_W] < duty);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      tick  <= '0;
      phase <= '0;
    end else if (en) begin
      if (tick_wrap) begin
        tick  <= '0;
        phase <= phase + PH_W'(1);
      end else begin
        tick <= tick + DIV_W'(1);
      end
    end
  end
endmodule

// File: rtl/cbm_bit_timer.sv
// Half-bit timer: marks second half, last cycle of a bit, and the cycle before it.
module cbm_bit_timer #(
  parameter int HALF_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              en,
  input  logic [HALF_W-1:0] half_len,
  output logic              second_half,
  output logic              bit_end,
  output logic              pre_end
);
  logic [HALF_W-1:0] hcnt;
  logic              half_q;
  logic              h_wrap;
  logic              short_half;

  assign h_wrap      = (hcnt == half_len);
  assign short_half  = (half_len == '0);
  assign second_half = half_q;
  assign bit_end     = half_q && h_wrap;
  assign pre_end     = (half_q && !short_half && (hcnt == half_len - HALF_W'(1)))
                    || (!half_q && short_half && (hcnt == '0));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      hcnt   <= '0;
      half_q <= 1'b0;
    end else if (en) begin
      if (h_wrap) begin
        hcnt   <= '0;
        half_q <= !half_q;
      end else begin
        hcnt <= hcnt + HALF_W'(1);
      end
    end
  end
endmodule

// File: rtl/cbm_line_coder.sv
// Symbol former for Manchester and Biphase; keeps the line level across bits.
module cbm_line_coder (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  input  logic biphase,
  input  logic data,
  input  logic second_half,
  input  logic bit_end,
  output logic sym
);
  logic last_lvl;
  logic first_lvl;
  logic man_sym;
  logic bip_sym;

  assign first_lvl = !last_lvl;
  assign man_sym   = second_half ? !data : data;
  assign bip_sym   = second_half ? (data ? first_lvl : !first_lvl) : first_lvl;
  assign sym       = biphase ? bip_sym : man_sym;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      last_lvl <= 1'b0;
    end else if (en && bit_end) begin
      last_lvl <= bip_sym;
    end
  end
endmodule

// File: rtl/carrier_biphase_mod.sv
module carrier_biphase_mod
  import cbm_pkg::*;
#(
  parameter int DIV_W   = 4,
  parameter int STEP_W  = 4,
  parameter int DUTY_W  = 2,
  parameter int PULSE_W = 8,
  parameter int HALF_W  = 8,
  parameter int BITS_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [1:0]         mode,
  input  logic [DIV_W-1:0]   div_sel,
  input  logic [DUTY_W-1:0]  duty,
  input  logic [PULSE_W-1:0] pulse_cnt,
  input  logic [HALF_W-1:0]  half_len,
  input  logic [BITS_W-1:0]  bit_len,
  input  logic               ser_data,
  output logic               data_req,
  output logic               mod_out,
  output logic               done
);
  localparam int CNT_W = (PULSE_W > BITS_W) ? PULSE_W : BITS_W;

  mod_mode_e          mode_in;
  mod_mode_e          mode_q;
  logic [DIV_W-1:0]   div_q;
  logic [DUTY_W-1:0]  duty_q;
  logic [HALF_W-1:0]  half_q;
  logic [CNT_W-1:0]   units_left;
  logic [CNT_W-1:0]   load_cnt;
  logic               active;
  logic               cur_bit;
  logic               launch;
  logic               carrier_q;
  logic               coded_q;
  logic               car_level;
  logic               per_end;
  logic               second_half;
  logic               bit_end;
  logic               pre_end;
  logic               code_sym;
  logic               unit_end;
  logic               final_c;
  logic               sym_now;

  assign mode_in   = mod_mode_e'(mode);
  assign launch    = !active && start && (mode_in != MOD_RSVD);
  assign load_cnt  = (mode_in == MOD_CARRIER) ? CNT_W'(pulse_cnt) : CNT_W'(bit_len);
  assign carrier_q = (mode_q == MOD_CARRIER);
  assign coded_q   = !carrier_q;
  assign unit_end  = carrier_q ? per_end : bit_end;
  assign final_c   = active && unit_end && (units_left == CNT_W'(1));
  assign sym_now   = carrier_q ? car_level : code_sym;

  cbm_carrier_gen #(
    .DIV_W (DIV_W),
    .STEP_W(STEP_W),
    .DUTY_W(DUTY_W)
  ) i_car (
    .clk       (clk),
    .rst       (rst),
    .clr       (launch),
    .en        (active),
    .div       (div_q),
    .duty      (duty_q),
    .level     (car_level),
    .period_end(per_end)
  );

  cbm_bit_timer #(
    .HALF_W(HALF_W)
  ) i_btm (
    .clk        (clk),
    .rst        (rst),
    .clr        (launch),
    .en         (active),
    .half_len   (half_q),
    .second_half(second_half),
    .bit_end    (bit_end),
    .pre_end    (pre_end)
  );

  cbm_line_coder i_code (
    .clk        (clk),
    .rst        (rst),
    .clr        (launch),
    .en         (active && coded_q),
    .biphase    (mode_q == MOD_BIPH),
    .data       (cur_bit),
    .second_half(second_half),
    .bit_end    (bit_end),
    .sym        (code_sym)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      active     <= 1'b0;
      done       <= 1'b0;
      mod_out    <= 1'b0;
      data_req   <= 1'b0;
      units_left <= '0;
      mode_q     <= MOD_CARRIER;
      div_q      <= '0;
      duty_q     <= '0;
      half_q     <= '0;
      cur_bit    <= 1'b0;
    end else if (launch) begin
      mode_q     <= mode_in;
      div_q      <= div_sel;
      duty_q     <= duty;
      half_q     <= half_len;
      units_left <= load_cnt;
      cur_bit    <= ser_data;
      active     <= (load_cnt != '0);
      done       <= (load_cnt == '0);
      mod_out    <= 1'b0;
      data_req   <= 1'b0;
    end else if (active) begin
      mod_out  <= sym_now;
      data_req <= coded_q && pre_end && (units_left > CNT_W'(1));
      if (unit_end) begin
        units_left <= units_left - CNT_W'(1);
      end
      if (bit_end) begin
        cur_bit <= ser_data;
      end
      if (final_c) begin
        active <= 1'b0;
        done   <= 1'b1;
      end
    end else begin
      mod_out  <= 1'b0;
      data_req <= 1'b0;
    end
  end
endmodule

// File: rtl/carrier_biphase_mod_chk.sv
module carrier_biphase_mod_chk #(
  parameter int PULSE_W = 8,
  parameter int BITS_W  = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               start,
  input logic [1:0]         mode,
  input logic [PULSE_W-1:0] pulse_cnt,
  input logic [BITS_W-1:0]  bit_len,
  input logic               active,
  input logic               data_req,
  input logic               mod_out,
  input logic               done
);
  // R1
  rst_low_chk: assert property (@(posedge clk)
    rst |=> (!mod_out && !data_req && !done));

  // R4
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |=> !mod_out);

  // R8
  req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    data_req |=> !data_req);

  // R8
  req_done_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !data_req);

  // R9
  zero_done_chk: assert property (@(posedge clk) disable iff (rst)
    (!active && start && (mode == 2'd0) && (pulse_cnt == '0)) |=> (done && !active));

  // R9
  zero_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (!active && start && (mode == 2'd1 || mode == 2'd2) && (bit_len == '0)) |=> (done && !active));

  // R10
  rsvd_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (!active && start && (mode == 2'd3)) |=> (!active && $stable(done)));
endmodule

bind carrier_biphase_mod carrier_biphase_mod_chk #(
  .PULSE_W(PULSE_W),
  .BITS_W (BITS_W)
) i_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .mode     (mode),
  .pulse_cnt(pulse_cnt),
  .bit_len  (bit_len),
  .active   (active),
  .data_req (data_req),
  .mod_out  (mod_out),
  .done     (done)
);

// File: tb/test_carrier_biphase_mod.sv
`timescale 1ns/1ps
module test_carrier_biphase_mod;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [3:0] div_sel = 4'd0;
  logic [1:0] duty = 2'd0;
  logic [7:0] pulse_cnt = 8'd0;
  logic [7:0] half_len = 8'd0;
  logic [7:0] bit_len = 8'd0;
  logic       ser_data;
  logic       data_req;
  logic       mod_out;
  logic       done;

  logic [31:0] frame_bits = 32'd0;
  int          fidx = 0;
  int          n_chk = 0;
  int          n_err = 0;
  string       cur_tag = "R1";

  always #2 clk = ~clk;

  assign ser_data = start ? frame_bits[0] : frame_bits[fidx[4:0]];

  always @(posedge clk) begin
    if (start) fidx <= 1;
    else if (data_req) fidx <= fidx + 1;
  end

  carrier_biphase_mod i_carrier_biphase_mod (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .div_sel(div_sel),
    .duty(duty), .pulse_cnt(pulse_cnt), .half_len(half_len), .bit_len(bit_len),
    .ser_data(ser_data), .data_req(data_req), .mod_out(mod_out), .done(done)
  );

  task automatic chk(input string tag, input string what, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s %s got=%0d exp=%0d at %0t", tag, what, got, exp, $time);
    end
  endtask

  // Behavioural reference model, stepped on every rising edge.
  bit m_act = 0, e_out = 0, e_req = 0, e_done = 0;
  int m_mode, m_div, m_duty, m_h, m_n, m_T, k;
  bit m_d, m_f;

  function automatic bit model_sym(int kk);
    int per, pos;
    bit sec;
    if (m_mode == 0) return (((kk / (m_div + 1)) % 64) / 16) < m_duty;
    per = 2 * m_h;
    pos = kk % per;
    sec = (pos >= m_h);
    if (m_mode == 1) return sec ? !m_d : m_d;
    return sec ? (m_d ? m_f : !m_f) : m_f;
  endfunction

  always @(posedge clk) begin
    int per;
    if (rst) begin
      m_act = 0; e_out = 0; e_req = 0; e_done = 0;
    end else if (!m_act && start && mode != 2'd3) begin
      m_mode = mode; m_div = div_sel; m_duty = duty; m_h = half_len + 1;
      m_n = (mode == 2'd0) ? pulse_cnt : bit_len;
      m_T = (mode == 2'd0) ? m_n * 64 * (m_div + 1) : m_n * 2 * m_h;
      k = 0; m_d = ser_data; m_f = 1;
      m_act = (m_n != 0); e_done = (m_n == 0); e_out = 0; e_req = 0;
    end else if (m_act) begin
      e_out = model_sym(k);
      if (m_mode != 0) begin
        per = 2 * m_h;
        e_req = (((k + 1) % per) == per - 1) && (((k + 1) / per) < m_n - 1);
        if ((k % per) == per - 1) begin
          m_f = !e_out;
          m_d = ser_data;
        end
      end else begin
        e_req = 0;
      end
      k++;
      if (k == m_T) begin
        m_act = 0;
        e_done = 1;
      end
    end else begin
      e_out = 0; e_req = 0;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk(cur_tag, "mod_out", mod_out, e_out);
      chk("R8", "data_req", data_req, e_req);
      chk(cur_tag, "done", done, e_done);
    end
  end

  task automatic run(input string tag, input int m, input int dv, input int du,
                     input int pc, input int hl, input int bl, input logic [31:0] bits);
    int w;
    cur_tag = tag;
    @(negedge clk);
    mode = 2'(m); div_sel = 4'(dv); duty = 2'(du); pulse_cnt = 8'(pc);
    half_len = 8'(hl); bit_len = 8'(bl); frame_bits = bits; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    w = 0;
    while (!done && w < 20000) begin
      @(negedge clk);
      w++;
    end
    chk(tag, "done at end", done, 1);
    @(negedge clk);
    chk(tag, "mod_out idle after done", mod_out, 0);
    if (m != 0) chk("R8", "bits handed over", fidx, bl);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog got=running exp=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "mod_out in reset", mod_out, 0);
    chk("R1", "data_req in reset", data_req, 0);
    chk("R1", "done in reset", done, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R2 / R4: two periods, duty 2, undivided
    run("R2 R4", 0, 0, 2, 2, 0, 0, 32'd0);
    // R3: duty 0 and duty 3
    run("R3", 0, 0, 0, 1, 0, 0, 32'd0);
    run("R3", 0, 1, 3, 1, 0, 0, 32'd0);

    // R10: divided carrier with mid-burst start and config changes
    cur_tag = "R10 R2";
    @(negedge clk);
    mode = 2'd0; div_sel = 4'd2; duty = 2'd1; pulse_cnt = 8'd1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (40) @(negedge clk);
    mode = 2'd1; duty = 2'd3; div_sel = 4'd0; bit_len = 8'd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    begin
      int w = 0;
      while (!done && w < 20000) begin
        @(negedge clk);
        w++;
      end
    end
    chk("R10", "done after ignored restart", done, 1);
    repeat (3) @(negedge clk);

    // R5 / R7 / R8: Manchester, 11 bits
    run("R5 R7", 1, 0, 0, 0, 1, 11, 32'b101_1001_0110);
    // R6 / R7: Biphase, 5 bits
    run("R6 R7", 2, 0, 0, 0, 2, 5, 32'b01101);
    // R6 / R8: Biphase, one-clock halves, 13 bits
    run("R6 R8", 2, 0, 0, 0, 0, 13, 32'b1_0011_1010_0110);
    // R5: Manchester, one-clock halves, 9 bits
    run("R5 R8", 1, 0, 0, 0, 0, 9, 32'b1_1100_1010);

    // R9: zero counts
    cur_tag = "R9";
    @(negedge clk);
    mode = 2'd0; pulse_cnt = 8'd0; duty = 2'd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9", "done after zero burst", done, 1);
    chk("R9", "mod_out after zero burst", mod_out, 0);
    repeat (4) @(negedge clk);
    mode = 2'd2; bit_len = 8'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9", "done after zero frame", done, 1);
    repeat (4) @(negedge clk);

    // R10: reserved mode start leaves done set and line low
    cur_tag = "R10";
    mode = 2'd3; pulse_cnt = 8'd4; bit_len = 8'd4; duty = 2'd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    chk("R10", "done after reserved start", done, 1);
    chk("R10", "mod_out after reserved start", mod_out, 0);

    // R1: reset in mid-burst
    cur_tag = "R2";
    mode = 2'd0; duty = 2'd3; pulse_cnt = 8'd3; div_sel = 4'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R1", "mod_out after reset", mod_out, 0);
    chk("R1", "done after reset", done, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule